// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block takes an asynchronous serial line and turns each character on it into a parallel byte. It works from a single-cycle clock enable that pulses sixteen times per bit period. The line first passes through a short synchronizer chain. A high-to-low transition in the idle state is treated only as a candidate start bit. The candidate is confirmed when the line is still low half a bit later. If the line has gone back high by then, the event is discarded and the receiver waits for the next falling edge.

Once the start bit is confirmed, the receiver samples one bit per sixteen enable ticks, each at the centre of its bit. The data bits arrive least significant first and are shifted into a working register, with parity accumulated as they arrive. An optional parity bit and then the stop bit are checked. The finished byte is copied into a holding register, where it stays, together with its error flags, until the host acknowledges it. Because the shift register and the holding register are separate, the next character can be received while the host is still reading the previous one.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `rx_valid`, `parity_err`, `frame_err`, `overrun` and `rx_data` are all zero.
- R2: A low pulse on `rx_in` that ends before 8 enable ticks after its falling edge delivers no byte, and `rx_valid` stays low.
- R3: Bits are sampled every 16 enable ticks at bit centres, least significant bit first. Bit k of the frame (counted from 0, after the start bit) appears at `rx_data[k]`.
- R4: When the stop bit of a frame has been sampled, `rx_data` holds the received byte and `rx_valid` is high.
- R5: `rx_valid` and `rx_data` hold their values until `rd_ack` is pulsed. An acknowledge with no new byte arriving in the same cycle clears `rx_valid`, `overrun` and both error flags.
- R6: With parity enabled (default, even: the data bits and the parity bit together hold an even number of ones), the single bit after the eighth data bit is checked. A mismatch sets `parity_err` for that byte.
- R7: A low level at the stop-bit sample sets `frame_err`, and the byte is still delivered with `rx_valid` high.
- R8: A byte that completes while `rx_valid` is still high sets `overrun`. The holding register then holds the newer byte.
- R9: The receive state advances only in cycles where `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Clock enable, 16 pulses per bit period |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rd_ack | input | 1 | Host read strobe, one cycle |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | A new byte is waiting in `rx_data` |
| parity_err | output | 1 | The held byte failed the parity check |
| frame_err | output | 1 | The held byte had a low stop bit |
| overrun | output | 1 | A byte was replaced before it was acknowledged |

## Verification
A tick counter that is off by one moves every sample away from the bit centre. The error grows along the frame, so it first corrupts the upper data bits or the parity and stop checks. It then shows as a wrong `rx_data` value or a false error flag after a single frame. A fault in start validation shows up either as a byte produced by a short glitch or as a real frame that is lost. Both are visible within one frame time. A fault in the holding logic appears at the ports within a cycle of a stop-bit sample or an acknowledge, as a flag that sticks, clears too early, or is missing on back-to-back bytes.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= IDLE_LVL;
            else        chain[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= IDLE_LVL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter bit PARITY_EN  = 1'b1,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic              done,
   output logic [DATA_W-1:0] word,
   output logic              perr,
   output logic              ferr
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
   localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("srx_frame: OVS must be even and at least 4");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("srx_frame: DATA_W must be positive");
   end

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] rsr;
   logic              par_acc;
   logic              last;
   logic              par_bad;
   rx_state_e         after_data;

   if (PARITY_EN) begin : g_par_on
      assign par_bad    = line ^ par_acc ^ PARITY_ODD;
      assign after_data = ST_PAR;
   end else begin : g_par_off
      assign par_bad    = 1'b0;
      assign after_data = ST_STOP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         rsr     <= '0;
         par_acc <= 1'b0;
         last    <= 1'b1;
         done    <= 1'b0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            last <= line;
            case (state)
               ST_IDLE: begin
                  if (last && !line) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == HALF_LAST) begin
                     cnt <= '0;
                     if (!line) begin
                        state   <= ST_DATA;
                        bitn    <= '0;
                        par_acc <= 1'b0;
                        perr    <= 1'b0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == CNT_LAST) begin
                     cnt     <= '0;
                     rsr     <= {line, rsr[DATA_W-1:1]};
                     par_acc <= par_acc ^ line;
                     if (bitn == BIT_LAST) state <= after_data;
                     else                  bitn  <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     perr  <= par_bad;
                     state <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     done  <= 1'b1;
                     ferr  <= !line;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign word = rsr;

   // R9: state moves only on an enable tick
   p_state_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state));
   // R2: a start candidate with the line back high at mid-bit is dropped
   p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && tick && cnt == HALF_LAST && line) |=> state == ST_IDLE);
   // R4: completion is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic              load_perr,
   input  logic              load_ferr,
   input  logic              ack,
   output logic [DATA_W-1:0] buf_word,
   output logic              valid,
   output logic              perr,
   output logic              ferr,
   output logic              ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_word <= '0;
         valid    <= 1'b0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         ovr      <= 1'b0;
      end else if (load) begin
         buf_word <= load_word;
         valid    <= 1'b1;
         perr     <= load_perr;
         ferr     <= load_ferr;
         ovr      <= valid && !ack;
      end else if (ack) begin
         valid <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
         ovr   <= 1'b0;
      end
   end

   // R5: unacknowledged byte stays flagged
   p_valid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ack) |=> valid);
   // R5: held byte does not change without a new completion
   p_word_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(buf_word));
   // R5: acknowledge without a new byte empties the buffer
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !load) |=> (!valid && !ovr));
   // R8: overrun only when a byte was already waiting
   p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(valid));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PARITY_EN   = 1'b1,
   parameter bit PARITY_ODD  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rx_in,
   input  logic              rd_ack,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun
);
   logic              line_s;
   logic              f_done;
   logic [DATA_W-1:0] f_word;
   logic              f_perr;
   logic              f_ferr;

   srx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .d_out (line_s)
   );

   srx_frame #(
      .DATA_W(DATA_W), .OVS(OVS),
      .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
   ) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .line  (line_s),
      .done  (f_done),
      .word  (f_word),
      .perr  (f_perr),
      .ferr  (f_ferr)
   );

   srx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (f_done),
      .load_word (f_word),
      .load_perr (f_perr),
      .load_ferr (f_ferr),
      .ack       (rd_ack),
      .buf_word  (rx_data),
      .valid     (rx_valid),
      .perr      (parity_err),
      .ferr      (frame_err),
      .ovr       (overrun)
   );

   // R1: nothing reported in the cycle after reset is released
   p_reset_quiet_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!rx_valid && !overrun && !parity_err && !frame_err));
endmodule

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;
   localparam int BIT_CLKS = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_in = 1'b1;
   logic       rd_ack = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, parity_err, frame_err, overrun;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tick16 <= 1'b0;
      else        tick16 <= ~tick16;
   end

   serial_byte_rx dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
      .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid),
      .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun)
   );

   // {data, flip parity, low stop}
   localparam logic [9:0] VEC [0:7] = '{
      {8'hA5, 2'b00}, {8'h3C, 2'b00}, {8'h00, 2'b00}, {8'hFF, 2'b00},
      {8'h01, 2'b10}, {8'h80, 2'b01}, {8'h5A, 2'b11}, {8'h96, 2'b00}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rx_in = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic flip, input logic stop_low);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      hold_bit((^d) ^ flip);
      hold_bit(!stop_low);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic ack_pulse();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid",   rx_valid, 0);
      check("R1 data",    rx_data, 0);
      check("R1 flags",   {parity_err, frame_err, overrun}, 0);
      repeat (40) @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         send(VEC[v][9:2], VEC[v][1], VEC[v][0]);
         check("R3 data", rx_data, VEC[v][9:2]);
         check("R4 valid", rx_valid, 1);
         check("R6 parity_err", parity_err, VEC[v][1]);
         check("R7 frame_err", frame_err, VEC[v][0]);
         check("R8 no overrun", overrun, 0);
         ack_pulse();
         check("R5 cleared", {rx_valid, parity_err, frame_err}, 0);
      end

      // R2: short glitch (3 ticks) is rejected
      rx_in = 1'b0;
      repeat (6) @(negedge clk);
      rx_in = 1'b1;
      repeat (12 * BIT_CLKS) @(negedge clk);
      check("R2 glitch ignored", rx_valid, 0);

      // R5: byte held without acknowledge
      send(8'hC3, 1'b0, 1'b0);
      repeat (600) @(negedge clk);
      check("R5 valid held", rx_valid, 1);
      check("R5 data held", rx_data, 8'hC3);

      // R8: second byte before acknowledge
      send(8'h4E, 1'b0, 1'b0);
      check("R8 overrun set", overrun, 1);
      check("R8 newest byte", rx_data, 8'h4E);
      check("R8 still valid", rx_valid, 1);
      ack_pulse();
      check("R8 overrun cleared", {overrun, rx_valid}, 0);

      // R9: no ticks, no progress
      @(negedge clk);
      force tick16 = 1'b0;
      send(8'h77, 1'b0, 1'b0);
      check("R9 frozen without ticks", rx_valid, 0);
      release tick16;
      repeat (4 * BIT_CLKS) @(negedge clk);
      send(8'h6B, 1'b0, 1'b0);
      check("R9 resumes", rx_data, 8'h6B);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule